// File: doc/BRIEF.md
# Dual-Thread Shared Store Buffer

This block holds the stores of two hardware threads that share one core. It keeps each store from issue, while it is still speculative, through retirement and until it is written to the data cache. Writes to the cache leave one per cycle, in the order in which the stores were allocated across both threads. A store counts as globally visible only once it has been written to the cache.

Loads look up the buffer to take data from a matching store still in it. A thread forwards from any of its own entries, speculative or not. The sibling thread forwards only from entries that have retired and are still waiting for the cache. A retired store can therefore reach the sibling before any other core sees it. A per-thread barrier stalls a thread until its retired stores have drained, and no cache-side action is needed for that. A mode input selects a split arrangement: each thread gets a fixed half of the entries, and the sibling never forwards from the other thread's entries.

Top module: `smt_stbuf`

## Requirements
- R1: After reset the buffer is empty: `full` is 2'b00, `cm_vld` is 0, and a lookup gives `ld_hit`=0 and `ld_stall`=0.
- R2: A load forwards from its own thread's entries whether or not they have retired. It gets `ld_hit`=1 and `ld_data` equal to the stored word when the store's byte enables cover every byte the load asks for.
- R3: When several eligible entries match the address, the lookup uses the most recently allocated one.
- R4: When the chosen entry shares some of the load's bytes but not all of them, `ld_stall`=1 and `ld_hit`=0.
- R5: In shared mode the sibling thread forwards only from retired, uncommitted entries. Speculative entries are invisible to it, and so are entries already written to the cache.
- R6: `cm_vld` offers the oldest entry across both threads, and only once that entry has retired. A younger retired entry waits behind an older unretired one. One entry leaves per cycle in which `cm_rdy`=1. While `cm_rdy`=0 the offered entry holds steady.
- R7: A pulse on `ret_vld[t]` retires the oldest unretired entry of thread t.
- R8: `flush[t]` removes every unretired entry of thread t. It keeps retired entries and the other thread's entries. It overrides an allocation or retirement for thread t in the same cycle.
- R9: `bar_stall[t]` is 1 while `bar_req[t]`=1 and thread t still has retired entries that have not been written to the cache.
- R10: In shared mode `mode_split`=0 and any thread may use any of the 8 entries. `full` is 2'b11 when all 8 are in use, and an allocation while the thread is full is dropped.
- R11: With `mode_split`=1, thread 0 owns entries 0 to 3 and thread 1 owns entries 4 to 7. `full[t]` reflects only the thread's own half, and a lookup never forwards from the other thread's entries, retired or not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | 0 = shared pool with sibling snooping, 1 = fixed halves with no sibling lookups; change only when empty |
| alc_vld | input | 1 | Allocate a store this cycle |
| alc_tid | input | 1 | Thread of the store being allocated |
| alc_addr | input | 16 | Word address of the store |
| alc_data | input | 32 | Store data |
| alc_be | input | 4 | Byte enables of the store |
| full | output | 2 | Per-thread full flag; allocation is dropped while set |
| ret_vld | input | 2 | Per-thread retire pulse |
| flush | input | 2 | Per-thread mis-speculation flush |
| ld_vld | input | 1 | Load lookup valid |
| ld_tid | input | 1 | Thread issuing the load |
| ld_addr | input | 16 | Load word address |
| ld_be | input | 4 | Bytes the load needs |
| ld_hit | output | 1 | Forwarded data is valid |
| ld_stall | output | 1 | Partial overlap, load must replay |
| ld_data | output | 32 | Forwarded data |
| cm_rdy | input | 1 | Cache accepts a store this cycle |
| cm_vld | output | 1 | A store is offered to the cache |
| cm_tid | output | 1 | Thread of the offered store |
| cm_addr | output | 16 | Address of the offered store |
| cm_data | output | 32 | Data of the offered store |
| cm_be | output | 4 | Byte enables of the offered store |
| bar_req | input | 2 | Per-thread barrier request |
| bar_stall | output | 2 | Barrier must keep waiting |

## Verification
Forwarding is tried with the same address stored twice by one thread, once before and once after the first copy retires. This separates youngest selection from oldest retirement. The same address is then looked up by the sibling, which separates the retired-only rule from plain address matching. Narrow stores probed with wide and narrow loads separate a full hit from a replay. Commits run with interleaved threads and with a retired store stuck behind an unretired older one, so a queue of expected stores in allocation order catches any out-of-order write. Filling the buffer in each mode tells the shared capacity apart from the per-half capacity.

// File: rtl/smt_sb_pkg.sv
package smt_sb_pkg;
  localparam int unsigned SB_NTHR = 2;

  typedef enum logic {
    SB_SHARED = 1'b0,
    SB_SPLIT  = 1'b1
  } sb_mode_e;
endpackage

// File: rtl/sb_age_matrix.sv
// Relative age of every pair of slots: bit [i*DEPTH+j] set means slot i
// was allocated before slot j. At most one slot is allocated per cycle.
module sb_age_matrix #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0]         alloc_oh,
  output logic [DEPTH*DEPTH-1:0]   older_o
);
  logic [DEPTH*DEPTH-1:0] mat_q, mat_n;

  always_comb begin
    mat_n = mat_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_oh[i]) begin
        for (int j = 0; j < DEPTH; j++) begin
          mat_n[i*DEPTH+j] = 1'b0;
          if (j != i) mat_n[j*DEPTH+i] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mat_q <= '0;
    else        mat_q <= mat_n;
  end

  assign older_o = mat_q;
endmodule

// File: rtl/sb_pick.sv
// Selects the oldest (or youngest) candidate slot from the age matrix.
module sb_pick #(
  parameter int unsigned DEPTH    = 8,
  parameter bit          YOUNGEST = 1'b0
) (
  input  logic [DEPTH-1:0]       cand_i,
  input  logic [DEPTH*DEPTH-1:0] older_i,
  output logic [DEPTH-1:0]       pick_o
);
  logic [DEPTH-1:0] beaten;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_comb begin
      beaten[i] = 1'b0;
      for (int j = 0; j < DEPTH; j++) begin
        if (YOUNGEST) beaten[i] = beaten[i] | (cand_i[j] & older_i[i*DEPTH+j]);
        else          beaten[i] = beaten[i] | (cand_i[j] & older_i[j*DEPTH+i]);
      end
    end
    assign pick_o[i] = cand_i[i] & ~beaten[i];
  end
endmodule

// File: rtl/sb_slot_alloc.sv
// Per-thread free-slot search and full flags, for both pool arrangements.
module sb_slot_alloc
  import smt_sb_pkg::*;
#(
  parameter int unsigned DEPTH = 8
) (
  input  logic                 mode_split,
  input  logic [DEPTH-1:0]     vld_i,
  input  logic                 req_i,
  input  logic                 req_tid,
  output logic [SB_NTHR-1:0]   full_o,
  output logic [DEPTH-1:0]     slot_o
);
  localparam int unsigned HALF = DEPTH / SB_NTHR;

  sb_mode_e mode;
  logic [DEPTH-1:0] free_t [SB_NTHR];
  logic [DEPTH-1:0] free_sel;

  assign mode = sb_mode_e'(mode_split);

  for (genvar t = 0; t < SB_NTHR; t++) begin : g_thr
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign free_t[t][i] = ~vld_i[i] & ((mode == SB_SHARED) || (i / HALF == t));
    end
    assign full_o[t] = ~|free_t[t];
  end

  assign free_sel = free_t[req_tid];

  always_comb begin
    logic found;
    found  = 1'b0;
    slot_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!found && free_sel[i]) begin
        slot_o[i] = req_i;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/smt_stbuf.sv
module smt_stbuf
  import smt_sb_pkg::*;
#(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_split,
  input  logic              alc_vld,
  input  logic              alc_tid,
  input  logic [ADDR_W-1:0] alc_addr,
  input  logic [DATA_W-1:0] alc_data,
  input  logic [DATA_W/8-1:0] alc_be,
  output logic [1:0]        full,
  input  logic [1:0]        ret_vld,
  input  logic [1:0]        flush,
  input  logic              ld_vld,
  input  logic              ld_tid,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W/8-1:0] ld_be,
  output logic              ld_hit,
  output logic              ld_stall,
  output logic [DATA_W-1:0] ld_data,
  input  logic              cm_rdy,
  output logic              cm_vld,
  output logic              cm_tid,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [DATA_W-1:0] cm_data,
  output logic [DATA_W/8-1:0] cm_be,
  input  logic [1:0]        bar_req,
  output logic [1:0]        bar_stall
);
  localparam int unsigned BE_W = DATA_W / 8;
  localparam int unsigned HALF = DEPTH / SB_NTHR;

  // control state and payload
  logic [DEPTH-1:0]  vld_q, vld_n, ret_q, ret_n;
  logic              tid_q  [DEPTH];
  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [BE_W-1:0]   be_q   [DEPTH];

  logic [DEPTH*DEPTH-1:0] older;
  logic [DEPTH-1:0] own_m   [SB_NTHR];
  logic [DEPTH-1:0] unret_m [SB_NTHR];
  logic [DEPTH-1:0] ret_oh  [SB_NTHR];
  logic [DEPTH-1:0] slot_oh, old_oh, cm_oh, match, fw_oh;
  logic             alc_go, fw_any, fw_cover, fw_tid, fw_ret;
  logic [BE_W-1:0]  fw_be;
  logic [DATA_W-1:0] fw_data;

  assign alc_go = alc_vld & ~full[alc_tid] & ~flush[alc_tid];

  sb_slot_alloc #(.DEPTH(DEPTH)) u_alloc (
    .mode_split (mode_split),
    .vld_i      (vld_q),
    .req_i      (alc_go),
    .req_tid    (alc_tid),
    .full_o     (full),
    .slot_o     (slot_oh)
  );

  sb_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk      (clk),
    .rst_n    (rst_n),
    .alloc_oh (slot_oh),
    .older_o  (older)
  );

  // per-thread views, retire selection and barrier
  for (genvar t = 0; t < SB_NTHR; t++) begin : g_thr
    for (genvar i = 0; i < DEPTH; i++) begin : g_own
      assign own_m[t][i] = vld_q[i] & (tid_q[i] == 1'(t));
    end
    assign unret_m[t] = own_m[t] & ~ret_q;

    sb_pick #(.DEPTH(DEPTH), .YOUNGEST(1'b0)) u_ret_pick (
      .cand_i  (unret_m[t]),
      .older_i (older),
      .pick_o  (ret_oh[t])
    );

    assign bar_stall[t] = bar_req[t] & |(own_m[t] & ret_q);
  end

  // commit: oldest live entry, offered only once retired
  sb_pick #(.DEPTH(DEPTH), .YOUNGEST(1'b0)) u_cm_pick (
    .cand_i  (vld_q),
    .older_i (older),
    .pick_o  (old_oh)
  );

  assign cm_oh  = old_oh & ret_q;
  assign cm_vld = |cm_oh;

  always_comb begin
    cm_tid  = 1'b0;
    cm_addr = '0;
    cm_data = '0;
    cm_be   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (cm_oh[i]) begin
        cm_tid  = cm_tid  | tid_q[i];
        cm_addr = cm_addr | addr_q[i];
        cm_data = cm_data | data_q[i];
        cm_be   = cm_be   | be_q[i];
      end
    end
  end

  // load lookup: own entries always, sibling entries only when retired in shared mode
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      match[i] = vld_q[i] & ld_vld & (addr_q[i] == ld_addr) & (|(be_q[i] & ld_be)) &
                 ((tid_q[i] == ld_tid) | (ret_q[i] & ~mode_split));
    end
  end

  sb_pick #(.DEPTH(DEPTH), .YOUNGEST(1'b1)) u_fw_pick (
    .cand_i  (match),
    .older_i (older),
    .pick_o  (fw_oh)
  );

  always_comb begin
    fw_tid  = 1'b0;
    fw_ret  = 1'b0;
    fw_be   = '0;
    fw_data = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (fw_oh[i]) begin
        fw_tid  = fw_tid  | tid_q[i];
        fw_ret  = fw_ret  | ret_q[i];
        fw_be   = fw_be   | be_q[i];
        fw_data = fw_data | data_q[i];
      end
    end
  end

  assign fw_any   = |fw_oh;
  assign fw_cover = ((fw_be & ld_be) == ld_be);
  assign ld_hit   = fw_any & fw_cover;
  assign ld_stall = fw_any & ~fw_cover;
  assign ld_data  = ld_hit ? fw_data : '0;

  // next state
  always_comb begin
    vld_n = vld_q;
    ret_n = ret_q;
    if (cm_vld && cm_rdy) begin
      vld_n = vld_n & ~cm_oh;
      ret_n = ret_n & ~cm_oh;
    end
    for (int t = 0; t < SB_NTHR; t++) begin
      if (flush[t])        vld_n = vld_n & ~unret_m[t];
      else if (ret_vld[t]) ret_n = ret_n | ret_oh[t];
    end
    if (alc_go) begin
      vld_n = vld_n | slot_oh;
      ret_n = ret_n & ~slot_oh;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ret_q <= '0;
    end else begin
      vld_q <= vld_n;
      ret_q <= ret_n;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_pay
    always_ff @(posedge clk) begin
      if (slot_oh[i]) begin
        tid_q[i]  <= alc_tid;
        addr_q[i] <= alc_addr;
        data_q[i] <= alc_data;
        be_q[i]   <= alc_be;
      end
    end
  end

  // assertions
  a_r6_commit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld && !cm_rdy |=> cm_vld && $stable(cm_addr) && $stable(cm_data) && $stable(cm_tid));

  a_r5_sibling_retired: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_hit || ld_stall) && (fw_tid != ld_tid) |-> fw_ret);

  a_r11_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
    mode_split && (ld_hit || ld_stall) |-> fw_tid == ld_tid);

  for (genvar t = 0; t < SB_NTHR; t++) begin : g_chk_thr
    a_r8_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush[t] |=> unret_m[t] == '0);
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_chk_slot
    a_r11_half_owner: assert property (@(posedge clk) disable iff (!rst_n)
      mode_split && vld_q[i] |-> tid_q[i] == 1'(i / HALF));
  end
endmodule

// File: tb/sim_smt_stbuf.sv
module sim_smt_stbuf;
  logic        clk, rst_n, mode_split;
  logic        alc_vld, alc_tid;
  logic [15:0] alc_addr;
  logic [31:0] alc_data;
  logic [3:0]  alc_be;
  logic [1:0]  full, ret_vld, flush, bar_req, bar_stall;
  logic        ld_vld, ld_tid, ld_hit, ld_stall;
  logic [15:0] ld_addr;
  logic [3:0]  ld_be;
  logic [31:0] ld_data;
  logic        cm_rdy, cm_vld, cm_tid;
  logic [15:0] cm_addr;
  logic [31:0] cm_data;
  logic [3:0]  cm_be;

  typedef struct packed {
    logic        tid;
    logic [15:0] addr;
    logic [31:0] data;
  } cm_item_t;

  cm_item_t exp_q [$];
  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  smt_stbuf u0 (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  // driver: allocations that will reach the cache push the expected commit
  task automatic alloc(bit t, logic [15:0] a, logic [31:0] d, logic [3:0] b, bit keep);
    alc_vld = 1'b1; alc_tid = t; alc_addr = a; alc_data = d; alc_be = b;
    if (keep) exp_q.push_back('{tid: t, addr: a, data: d});
    step();
    alc_vld = 1'b0;
  endtask

  task automatic retire(logic [1:0] m);
    ret_vld = m;
    step();
    ret_vld = 2'b00;
  endtask

  task automatic lookup(bit t, logic [15:0] a, logic [3:0] b,
                        bit e_hit, bit e_stall, logic [31:0] e_data, string req);
    logic [33:0] act, exp;
    ld_vld = 1'b1; ld_tid = t; ld_addr = a; ld_be = b;
    #2;
    act = {ld_hit, ld_stall, ld_data};
    exp = {e_hit, e_stall, e_data};
    chk(act == exp, req, 64'(act), 64'(exp));
    ld_vld = 1'b0;
  endtask

  // monitor: every accepted commit is compared against the expected order
  always @(negedge clk) begin
    if (rst_n && cm_vld && cm_rdy) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R6 unexpected commit", 64'({cm_tid, cm_addr, cm_data}), 64'(0));
      end else begin
        cm_item_t e;
        e = exp_q.pop_front();
        chk({cm_tid, cm_addr, cm_data} == e, "R6 commit order",
            64'({cm_tid, cm_addr, cm_data}), 64'(e));
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'(0), 64'(1));
    finish_run();
  end

  initial begin
    rst_n = 1'b0; mode_split = 1'b0; alc_vld = 1'b0; alc_tid = 1'b0;
    alc_addr = '0; alc_data = '0; alc_be = '0; ret_vld = '0; flush = '0;
    ld_vld = 1'b0; ld_tid = 1'b0; ld_addr = '0; ld_be = '0;
    cm_rdy = 1'b0; bar_req = '0;
    wait_n(3);
    rst_n = 1'b1;
    step();

    // R1 reset state
    chk({full, cm_vld} == 3'b000, "R1 full/cm_vld", 64'({full, cm_vld}), 64'(0));
    lookup(0, 16'h0010, 4'hF, 0, 0, 32'h0, "R1 empty lookup");

    // R2 own speculative forwarding, R5 sibling blind to it
    alloc(0, 16'h0010, 32'h1111_1111, 4'hF, 1);
    lookup(0, 16'h0010, 4'hF, 1, 0, 32'h1111_1111, "R2 own speculative");
    lookup(1, 16'h0010, 4'hF, 0, 0, 32'h0, "R5 sibling speculative hidden");

    // R3 youngest wins
    alloc(0, 16'h0010, 32'h2222_2222, 4'hF, 1);
    lookup(0, 16'h0010, 4'hF, 1, 0, 32'h2222_2222, "R3 youngest match");

    // R4 partial overlap
    alloc(0, 16'h0020, 32'h3333_3333, 4'h3, 1);
    lookup(0, 16'h0020, 4'hF, 0, 1, 32'h0, "R4 partial overlap stall");
    lookup(0, 16'h0020, 4'h3, 1, 0, 32'h3333_3333, "R4 covered narrow load");

    // R7 retire oldest; R5 sibling sees only the retired older copy
    retire(2'b01);
    lookup(1, 16'h0010, 4'hF, 1, 0, 32'h1111_1111, "R5 R7 sibling sees retired oldest");
    bar_req = 2'b11;
    #1;
    chk(bar_stall == 2'b01, "R9 barrier stall", 64'(bar_stall), 64'(2'b01));
    bar_req = 2'b00;

    // R8 flush of thread 1
    alloc(1, 16'h0030, 32'h4444_4444, 4'hF, 1);
    alloc(1, 16'h0040, 32'h5555_5555, 4'hF, 0);
    retire(2'b10);
    flush = 2'b10;
    alc_vld = 1'b1; alc_tid = 1'b1; alc_addr = 16'h0050; alc_data = 32'h6666_6666; alc_be = 4'hF;
    step();
    flush = 2'b00; alc_vld = 1'b0;
    lookup(1, 16'h0040, 4'hF, 0, 0, 32'h0, "R8 flushed entry gone");
    lookup(1, 16'h0050, 4'hF, 0, 0, 32'h0, "R8 flush beats alloc");
    lookup(1, 16'h0030, 4'hF, 1, 0, 32'h4444_4444, "R8 retired kept");
    lookup(0, 16'h0020, 4'h3, 1, 0, 32'h3333_3333, "R8 other thread kept");

    // R6 commit order and blocking behind an unretired oldest entry
    cm_rdy = 1'b1;
    wait_n(4);
    chk(cm_vld == 1'b0, "R6 blocked behind unretired", 64'(cm_vld), 64'(0));
    bar_req = 2'b10;
    #1;
    chk(bar_stall == 2'b10, "R9 sibling barrier waits", 64'(bar_stall), 64'(2'b10));
    bar_req = 2'b00;
    retire(2'b01);
    retire(2'b01);
    wait_n(6);
    chk(exp_q.size() == 0, "R6 drained", 64'(exp_q.size()), 64'(0));
    bar_req = 2'b11;
    #1;
    chk(bar_stall == 2'b00, "R9 barrier released", 64'(bar_stall), 64'(0));
    bar_req = 2'b00;
    lookup(1, 16'h0010, 4'hF, 0, 0, 32'h0, "R5 committed not forwarded");

    // R10 shared capacity
    cm_rdy = 1'b0;
    for (int i = 0; i < 8; i++)
      alloc(i[0], 16'h0100 + 16'(i), 32'hA000_0000 + 32'(i), 4'hF, 1);
    chk(full == 2'b11, "R10 full at 8", 64'(full), 64'(2'b11));
    alloc(0, 16'h0199, 32'hDEAD_BEEF, 4'hF, 0);
    lookup(0, 16'h0199, 4'hF, 0, 0, 32'h0, "R10 alloc when full dropped");
    for (int i = 0; i < 4; i++) retire(2'b11);
    cm_rdy = 1'b1;
    wait_n(12);
    chk(exp_q.size() == 0, "R10 R6 drained", 64'(exp_q.size()), 64'(0));
    chk(full == 2'b00, "R10 empty again", 64'(full), 64'(0));

    // R11 split mode
    cm_rdy = 1'b0;
    mode_split = 1'b1;
    for (int i = 0; i < 4; i++)
      alloc(0, 16'h0200 + 16'(i), 32'hB000_0000 + 32'(i), 4'hF, 1);
    chk(full == 2'b01, "R11 half full", 64'(full), 64'(2'b01));
    alloc(0, 16'h02FF, 32'hDEAD_0000, 4'hF, 0);
    lookup(0, 16'h02FF, 4'hF, 0, 0, 32'h0, "R11 fifth alloc dropped");
    for (int i = 0; i < 4; i++) retire(2'b01);
    lookup(1, 16'h0200, 4'hF, 0, 0, 32'h0, "R11 no sibling forwarding");
    alloc(1, 16'h0300, 32'hC000_0000, 4'hF, 1);
    lookup(1, 16'h0300, 4'hF, 1, 0, 32'hC000_0000, "R11 own half forwards");
    chk(full == 2'b01, "R11 sibling half free", 64'(full), 64'(2'b01));
    retire(2'b10);
    cm_rdy = 1'b1;
    wait_n(10);
    chk(exp_q.size() == 0, "R11 R6 drained", 64'(exp_q.size()), 64'(0));
    mode_split = 1'b0;

    finish_run();
  end
endmodule